// File: doc/BRIEF.md
# Fractional Scale-Step Baud Generator

This block produces a serial bit-rate tick from the system clock, using two programmable fields. An integer prescaler divides the clock by `scale + 1`. On every prescaled enable, a 16-bit `step` is added into a 17-bit phase register, and each carry out of that register becomes one output tick. The long-run tick rate is therefore `f_clk * step / ((scale + 1) * 2^17)`. Because the phase is fractional, the rate can be set much more finely than a plain integer divider allows.

Software picks the `scale`/`step` pair for a wanted bit rate and holds it on the inputs. Whenever either field changes value, the generator restarts from a clean state, so the new rate applies from a known phase. A low `en` freezes the generator without losing its phase.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `tick` is 0, and the prescaler count and the phase are cleared.
- R2: While `en` is high and the configuration is steady, the prescaler issues one enable every `scale + 1` clocks. A `scale` of 0 issues an enable on every clock, and the largest `scale`, 4095, issues one every 4096 clocks.
- R3: Each enable adds `step` into the 17-bit phase, which keeps the low 17 bits of the sum. A carry out of bit 16 raises `tick` on the clock edge at which the add is registered. Counting from the edge that follows a configuration change, `tick` is therefore high exactly floor(floor(M/(scale+1)) * step / 2^17) times in the next M clocks.
- R4: A `step` of 0 produces no ticks at any `scale`.
- R5: Every 16-bit `step` value up to 0xFFFF is accepted, and it obeys the rate law of R3.
- R6: While `en` is low, the prescaler count and the phase hold their values and `tick` stays 0. When `en` returns high, counting resumes from the held state.
- R7: When `scale` or `step` differs from its value at the previous clock edge, the next edge clears the prescaler count, the phase and `tick`.
- R8: `tick` is a single-cycle pulse and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low freezes the generator |
| scale | input | 12 | Prescale value; the divide ratio is scale+1 |
| step | input | 16 | Phase increment added on each prescaled enable |
| tick | output | 1 | One-cycle pulse for each phase carry |

## Verification
The assertions assume that `scale` and `step` are synchronous to `clk` and stay steady between deliberate changes. They also assume that the phase is wider than the step, which makes back-to-back carries impossible. The stimulus changes `scale`, `step` and `en` only just after a falling edge. It forces a visible change before each measured window, so every window starts from the cleared state that the rate formula assumes. The tick counts are sampled on falling edges and compared against the closed-form count, not against a model of the registers.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // Default field widths of the generator.
  localparam int unsigned FBG_SCALE_W = 12;
  localparam int unsigned FBG_STEP_W  = 16;
  localparam int unsigned FBG_PHASE_W = 17;

  // Reason the generator restarts on a given cycle.
  typedef enum logic [1:0] {
    FBG_RUN     = 2'd0,
    FBG_NEW_DIV = 2'd1,
    FBG_NEW_INC = 2'd2,
    FBG_NEW_ALL = 2'd3
  } fbg_restart_e;
endpackage

// File: rtl/fbg_cfg_watch.sv
module fbg_cfg_watch
  import fbg_pkg::*;
#(
  parameter int unsigned SCALE_W = FBG_SCALE_W,
  parameter int unsigned STEP_W  = FBG_STEP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCALE_W-1:0] scale,
  input  logic [STEP_W-1:0]  step,
  output fbg_restart_e       cause,
  output logic               restart
);
  logic [SCALE_W-1:0] scale_seen;
  logic [STEP_W-1:0]  step_seen;

  // Remember the fields as they stood at the previous edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_seen <= '0;
      step_seen  <= '0;
    end else begin
      scale_seen <= scale;
      step_seen  <= step;
    end
  end

  function automatic fbg_restart_e classify(input logic div_moved, input logic inc_moved);
    fbg_restart_e r;
    unique case ({inc_moved, div_moved})
      2'b00:   r = FBG_RUN;
      2'b01:   r = FBG_NEW_DIV;
      2'b10:   r = FBG_NEW_INC;
      default: r = FBG_NEW_ALL;
    endcase
    return r;
  endfunction

  always_comb begin
    cause   = classify(scale != scale_seen, step != step_seen);
    restart = (cause != FBG_RUN);
  end
endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int unsigned SCALE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale,
  output logic [SCALE_W-1:0] count,
  output logic               fire
);
  logic wrap;

  // The count has reached the divide limit.
  function automatic logic at_limit(input logic [SCALE_W-1:0] c, input logic [SCALE_W-1:0] lim);
    return (c >= lim);
  endfunction

  function automatic logic [SCALE_W-1:0] advance(input logic [SCALE_W-1:0] c, input logic w);
    return w ? '0 : c + 1'b1;
  endfunction

  always_comb begin
    wrap = at_limit(count, scale);
    fire = en && !clr && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (en)     count <= advance(count, wrap);
  end
endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
  parameter int unsigned STEP_W  = 16,
  parameter int unsigned PHASE_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  logic [STEP_W-1:0]  step,
  output logic [PHASE_W-1:0] phase,
  output logic               carry,
  output logic               tick
);
  localparam int unsigned SUM_W = PHASE_W + 1;

  logic [PHASE_W-1:0] inc;
  logic [SUM_W-1:0]   sum;

  // Widen the step to the phase width (or trim it if a variant is narrower).
  generate
    if (PHASE_W > STEP_W) begin : g_pad
      assign inc = {{(PHASE_W-STEP_W){1'b0}}, step};
    end else begin : g_trim
      assign inc = step[PHASE_W-1:0];
    end
  endgenerate

  function automatic logic [SUM_W-1:0] phase_add(input logic [PHASE_W-1:0] p,
                                                 input logic [PHASE_W-1:0] d);
    return {1'b0, p} + {1'b0, d};
  endfunction

  always_comb begin
    sum   = phase_add(phase, inc);
    carry = sum[SUM_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      tick  <= 1'b0;
    end else if (clr) begin
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= adv && carry;
      if (adv) phase <= sum[PHASE_W-1:0];
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int unsigned SCALE_W = FBG_SCALE_W,
  parameter int unsigned STEP_W  = FBG_STEP_W,
  parameter int unsigned PHASE_W = FBG_PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale,
  input  logic [STEP_W-1:0]  step,
  output logic               tick
);
  // Named internal events, brought out for the checker.
  fbg_restart_e       restart_cause;
  logic               cfg_restart;
  logic               pre_fire;
  logic               phase_carry;
  logic [SCALE_W-1:0] pre_count;
  logic [PHASE_W-1:0] phase_now;

  fbg_cfg_watch #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .scale   (scale),
    .step    (step),
    .cause   (restart_cause),
    .restart (cfg_restart)
  );

  fbg_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_restart),
    .en    (en),
    .scale (scale),
    .count (pre_count),
    .fire  (pre_fire)
  );

  fbg_phase_acc #(.STEP_W(STEP_W), .PHASE_W(PHASE_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_restart),
    .adv   (pre_fire),
    .step  (step),
    .phase (phase_now),
    .carry (phase_carry),
    .tick  (tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int unsigned SCALE_W = 12,
  parameter int unsigned STEP_W  = 16,
  parameter int unsigned PHASE_W = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic [STEP_W-1:0]  step,
  input logic               tick,
  input logic               cfg_restart,
  input logic               pre_fire,
  input logic               phase_carry,
  input logic [SCALE_W-1:0] pre_count,
  input logic [PHASE_W-1:0] phase_now
);
  // R8: a tick never lasts two cycles
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R2: a prescaler enable returns the count to zero
  p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |=> (pre_count == '0));

  // R3: an enable that carries yields a tick on the next edge
  p_carry_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_fire && phase_carry) |=> tick);

  // R3: every tick is traced back to a carrying enable
  p_tick_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(pre_fire && phase_carry));

  // R4: zero step never ticks
  p_zero_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0) |=> !tick);

  // R6: disabled generator holds its state
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cfg_restart) |=> ($stable(pre_count) && $stable(phase_now) && !tick));

  // R7: a configuration change clears everything
  p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_restart |=> (pre_count == '0 && phase_now == '0 && !tick));
endmodule

bind frac_baud_gen fbg_checker #(
  .SCALE_W(SCALE_W), .STEP_W(STEP_W), .PHASE_W(PHASE_W)
) u_fbg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .step        (step),
  .tick        (tick),
  .cfg_restart (cfg_restart),
  .pre_fire    (pre_fire),
  .phase_carry (phase_carry),
  .pre_count   (pre_count),
  .phase_now   (phase_now)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [11:0] scale = '0;
  logic [15:0] step = '0;
  logic        tick;

  int total = 0;
  int bad = 0;
  longint tick_total = 0;
  int back_to_back = 0;
  logic prev_tick = 1'b0;
  bit done = 1'b0;

  typedef struct {
    string  tag;
    longint exp;
    longint act;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  frac_baud_gen uut (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .scale (scale),
    .step  (step),
    .tick  (tick)
  );

  // Monitor: counts ticks at falling edges and looks for back-to-back pulses.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick) tick_total <= tick_total + 1;
      if (tick && prev_tick) back_to_back <= back_to_back + 1;
      prev_tick <= tick;
    end
  end

  // Scoreboard: pops expected/actual pairs and compares them.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (it.act !== it.exp) begin
          bad++;
          $display("FAIL %s: got %0d expected %0d", it.tag, it.act, it.exp);
        end
      end
    end
  end

  function automatic longint rate_count(longint s, longint t, longint m);
    return ((m / (s + 1)) * t) >> 17;
  endfunction

  task automatic push(string tag, longint exp, longint act);
    item_t it;
    it.tag = tag; it.exp = exp; it.act = act;
    sb_q.push_back(it);
  endtask

  // Drives a forced change and then the wanted fields; returns just after the clearing edge.
  task automatic apply_cfg(int s, int t);
    @(negedge clk);
    step = ~t[15:0];
    @(negedge clk);
    scale = s[11:0];
    step  = t[15:0];
    @(posedge clk);
  endtask

  task automatic measure(int m, output longint got);
    longint start;
    start = tick_total;
    repeat (m) @(posedge clk);
    @(negedge clk);
    #1;
    got = tick_total - start;
  endtask

  task automatic window(string tag, int s, int t, int m);
    longint got;
    apply_cfg(s, t);
    measure(m, got);
    push(tag, rate_count(s, t, m), got);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint got;
    // R1: reset holds tick low
    scale = 12'd0; step = 16'hFFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    push("R1 tick during reset", 0, longint'(tick));
    rst_n = 1'b1;

    // R4: zero step, fast and slow prescale
    window("R4 step zero scale 0", 0, 0, 500);
    window("R4 step zero scale 5", 5, 0, 600);

    // R3 / R5: rate law across patterns
    window("R5 step max scale 0", 0, 16'hFFFF, 1000);
    window("R3 step 12345 scale 7", 7, 12345, 20000);
    window("R3 step 1 scale 0", 0, 1, 3000);
    window("R2 scale 3 step 0x4000", 3, 16'h4000, 4000);
    window("R2 scale 9 step 0x9999", 9, 16'h9999, 8000);
    window("R5 scale 4095 step max", 4095, 16'hFFFF, 100000);

    // R6: disabled generator keeps its phase
    apply_cfg(0, 16'h8000);
    measure(6, got);
    push("R3 four enables per tick", 1, got);
    en = 1'b0;
    measure(50, got);
    push("R6 no tick while disabled", 0, got);
    en = 1'b1;
    measure(2, got);
    push("R6 phase held across pause", 1, got);

    // R7: step change clears the phase
    apply_cfg(0, 16'h8000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    step = 16'h8001;
    @(posedge clk);
    measure(1, got);
    push("R7 step change clears phase", 0, got);

    // R7: scale change clears count and phase
    apply_cfg(2, 16'hFFFF);
    repeat (12) @(posedge clk);
    @(negedge clk);
    scale = 12'd1;
    @(posedge clk);
    measure(2, got);
    push("R7 scale change clears state", 0, got);

    repeat (4) @(negedge clk);
    // R8: no consecutive tick cycles in the whole run
    total++;
    if (back_to_back != 0) begin
      bad++;
      $display("FAIL R8 back-to-back ticks: got %0d expected 0", back_to_back);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule